// File: doc/BRIEF.md
# Serial Hex Digit Debug Display

This block puts a 16-bit debug word, normally a processor's program counter, on a single seven-segment digit. One digit can show only one hex character at a time. The block therefore steps through the four nibbles of the word in turn, holding each one for a fixed number of clock cycles. After the fourth nibble it blanks the digit for a separate fixed interval. The blank gap marks where one word ends and the next begins.

The word is sampled once, at the start of each four-digit run. All four characters therefore come from one consistent value, even while the counter keeps moving. A synchronous active-high clear blanks the digit and holds the sequencer. An asynchronous active-low reset does the same. An opcode word is present on the interface, but it does not affect what is shown. Both dwell lengths are parameters, so a simulation can use short intervals and hardware can use visible ones.

Top module: `serial_hex_display`

## Requirements
- R1: Segment output bit 0 drives segment a through bit 6 for segment g, active high. The hex characters encode as 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F, A=0x77, b=0x7C, C=0x39, d=0x5E, E=0x79, F=0x71.
- R2: A run shows the captured word's nibbles from bits 15:12 down to bits 3:0, and each nibble stays on seg_o for exactly DIGIT_CYCLES consecutive cycles.
- R3: After the last nibble, seg_o is 0 for exactly GAP_CYCLES cycles. The next run then starts again with the most significant nibble.
- R4: The word is captured from pc_i at the clock edge that starts a run. Changes on pc_i during the run do not alter the characters shown.
- R5: While clr_i is sampled high, seg_o is 0 from the following cycle onward. The first edge that samples clr_i low starts a new run, with the capture of R4.
- R6: While rst_ni is low, seg_o is 0. The first edge after its release starts a run exactly as in R5.
- R7: opc_i has no effect on seg_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, active high |
| pc_i | input | 16 | Program counter value to display |
| opc_i | input | 16 | Opcode word, accepted and not displayed |
| seg_o | output | 7 | Segment drive, bit 0 = a to bit 6 = g, active high |

## Verification
A wrong dwell count or a wrong digit index appears on seg_o as soon as the pattern first changes. That is at most one digit time, or one gap time, after the fault: a character is held too long, shows up out of order, or blanks early. A capture register that loads at the wrong moment shows a stale or mixed character within the same run, because pc_i is randomised every cycle. A wrong clear or restart path shows in the cycle right after clr_i changes, as a missing blank or as a first character that is not the top nibble.

// File: rtl/serial_hex_pkg.sv
package serial_hex_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SHOW = 2'd1,
    PH_GAP  = 2'd2
  } phase_e;

  // bit 0 = segment a ... bit 6 = segment g, active high
  function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
    logic [6:0] s;
    unique case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/serial_hex_dwell_timer.sv
module serial_hex_dwell_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [CW-1:0] last_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || done_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bounded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));

endmodule

// File: rtl/serial_hex_sequencer.sv
module serial_hex_sequencer
  import serial_hex_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int DIGITS = VAL_W / 4,
  parameter int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             done_i,
  output logic             restart_o,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VAL_W-1:0] cap_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [VAL_W-1:0] cap_q;
  logic             load;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    load    = 1'b0;
    if (clr_i) begin
      phase_d = PH_IDLE;
      idx_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_SHOW;
          idx_d   = '0;
          load    = 1'b1;
        end
        PH_SHOW: if (done_i) begin
          if (idx_q == IDX_LAST) phase_d = PH_GAP;
          else                   idx_d   = idx_q + 1'b1;
        end
        PH_GAP: if (done_i) begin
          phase_d = PH_SHOW;
          idx_d   = '0;
          load    = 1'b1;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cap_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      if (load) cap_q <= val_i;
    end
  end

  assign restart_o = clr_i || (phase_q == PH_IDLE);
  assign phase_o   = phase_q;
  assign idx_o     = idx_q;
  assign cap_o     = cap_q;

  p_idx_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_q == PH_SHOW && done_i && idx_q != IDX_LAST)
      |=> (phase_q == PH_SHOW && idx_q == $past(idx_q) + 1'b1));

  p_gap_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_q == PH_GAP && done_i) |=> (phase_q == PH_SHOW && idx_q == '0));

  p_cap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SHOW) |=> $stable(cap_q));

  p_idle_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && phase_q == PH_IDLE) |=> (phase_q == PH_SHOW && idx_q == '0 && cap_q == $past(val_i)));

endmodule

// File: rtl/serial_hex_encoder.sv
module serial_hex_encoder
  import serial_hex_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int DIGITS = VAL_W / 4,
  parameter int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  phase_e           phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VAL_W-1:0] cap_i,
  output logic [6:0]       seg_o
);

  logic [DIGITS-1:0][3:0] nibs;
  logic [3:0]             nib_sel;

  // nibs[0] is the most significant nibble, shown first
  for (genvar g = 0; g < DIGITS; g++) begin : g_nib
    assign nibs[g] = cap_i[VAL_W-1-4*g -: 4];
  end

  always_comb begin
    nib_sel = '0;
    for (int i = 0; i < DIGITS; i++)
      if (idx_i == IDX_W'(i)) nib_sel = nibs[i];
  end

  assign seg_o = (phase_i == PH_SHOW) ? hex_to_seg(nib_sel) : 7'd0;

endmodule

// File: rtl/serial_hex_display.sv
module serial_hex_display
  import serial_hex_pkg::*;
#(
  parameter int DIGIT_CYCLES = 2_500_000,
  parameter int GAP_CYCLES   = 5_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic [15:0] pc_i,
  input  logic [15:0] opc_i,
  output logic [6:0]  seg_o
);

  localparam int VAL_W  = 16;
  localparam int DIGITS = VAL_W / 4;
  localparam int IDX_W  = $clog2(DIGITS);
  localparam int MAXC   = (DIGIT_CYCLES > GAP_CYCLES) ? DIGIT_CYCLES : GAP_CYCLES;
  localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] SHOW_LAST = CW'(DIGIT_CYCLES - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYCLES - 1);

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic [VAL_W-1:0] cap;
  logic             done, restart;
  logic [CW-1:0]    last;
  logic             unused_opc;

  assign unused_opc = ^opc_i;
  assign last       = (phase == PH_GAP) ? GAP_LAST : SHOW_LAST;

  serial_hex_dwell_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .last_i    (last),
    .done_o    (done)
  );

  serial_hex_sequencer #(.VAL_W(VAL_W), .DIGITS(DIGITS), .IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .val_i     (pc_i),
    .done_i    (done),
    .restart_o (restart),
    .phase_o   (phase),
    .idx_o     (idx),
    .cap_o     (cap)
  );

  serial_hex_encoder #(.VAL_W(VAL_W), .DIGITS(DIGITS), .IDX_W(IDX_W)) u_enc (
    .phase_i (phase),
    .idx_i   (idx),
    .cap_i   (cap),
    .seg_o   (seg_o)
  );

  initial begin
    assert (DIGIT_CYCLES >= 1 && GAP_CYCLES >= 1);
  end

  p_clr_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (seg_o == 7'd0));

  p_gap_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_GAP) |-> (seg_o == 7'd0));

endmodule

// File: tb/serial_hex_display_test.sv
module serial_hex_display_test;

  localparam int D = 3;
  localparam int G = 5;
  localparam int P = 4 * D + G;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] pc = '0;
  logic [15:0] opc = '0;
  logic [6:0]  seg;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  bit          m_idle = 1;
  int          m_t = 0;
  logic [15:0] m_val = '0;

  always #10 clk = ~clk;

  serial_hex_display #(.DIGIT_CYCLES(D), .GAP_CYCLES(G)) uut (
    .clk_i (clk), .rst_ni(rst_n), .clr_i(clr),
    .pc_i  (pc),  .opc_i (opc),   .seg_o(seg)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  // advance the reference over one clock edge with the inputs it sampled
  task automatic model_edge();
    if (!rst_n || clr) m_idle = 1;
    else if (m_idle) begin m_idle = 0; m_t = 0; m_val = pc; end
    else begin
      m_t++;
      if (m_t == P) begin m_t = 0; m_val = pc; end
    end
  endtask

  task automatic check_now();
    logic [6:0] exp;
    string tag;
    if (!rst_n)        begin exp = 7'd0; tag = "R6"; end
    else if (m_idle)   begin exp = 7'd0; tag = "R5"; end
    else if (m_t < 4*D) begin
      exp = ref_seg(4'((m_val >> (4 * (3 - m_t / D))) & 16'hF));
      tag = "R1 R2 R4 R7";
    end else           begin exp = 7'd0; tag = "R3"; end
    n_vec++;
    if (seg !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d: seg=%h expected %h", tag, m_t, seg, exp);
    end
  endtask

  // one cycle: account for the edge just past, check, then drive next inputs
  task automatic cyc(input bit c, input logic [15:0] p);
    @(negedge clk);
    if (rst_n) model_edge();
    check_now();
    clr = c;
    pc  = p;
    opc = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R6: held in reset, blank
    repeat (3) begin
      @(negedge clk);
      check_now();
    end
    pc = 16'h1234;
    rst_n = 1'b1;
    // R2 R3: steady value over two full periods
    repeat (2 * P) cyc(0, 16'h1234);
    // R4: pc changes every cycle, display stays on captured value
    repeat (2 * P) cyc(0, 16'($urandom));
    // R1: all-ones and all-zero words, plus every hex character
    repeat (P) cyc(0, 16'hFFFF);
    repeat (P) cyc(0, 16'h0000);
    repeat (P) cyc(0, 16'h89AB);
    repeat (P) cyc(0, 16'hCDEF);
    repeat (P) cyc(0, 16'h4567);
    // R5: clear mid-run for three cycles, then a one-cycle clear
    repeat (5) cyc(0, 16'hABCD);
    repeat (3) cyc(1, 16'h5A5A);
    repeat (P + 4) cyc(0, 16'hBEEF);
    cyc(1, 16'h0F0F);
    repeat (2 * P) cyc(0, 16'hD00D);
    // random mix
    repeat (3000) cyc(($urandom % 64) == 0, 16'($urandom));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100_000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule